// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer with Wait-State Insertion

This block steps a simple processor bus through the clock phases of one memory or I/O transfer: an address phase (T1), a strobe phase (T2), a ready-sampling phase (T3), zero or more wait phases (Tw) and a closing phase (T4). Each request is a read or a write with an address and, for writes, a data byte. The block drives the address latch enable, the address and data output enables and the read and write strobes. For reads it returns the captured data.

The block lengthens a cycle in two ways. An expansion-slot device can hold its channel-ready line low, and a per-cycle minimum wait count can force extra wait phases even when the slot is ready. A DMA address-enable input (`aen`) marks the bus as owned by another master. While `aen` is high the block drives nothing. A request that arrives in that time waits inside the block until the bus is released.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `t_state` is 0 (idle). `bus_ale`, `bus_rd`, `bus_wr`, `bus_addr_oe`, `bus_data_oe`, `busy` and `rd_valid` are all low.
- R2: The `t_state` encoding is idle=0, T1=1, T2=2, T3=3, Tw=4, T4=5. Suppose `req_valid` is high in idle and `aen` is low at the same clock edge. Then the next cycle is T1, with `bus_ale` and `bus_addr_oe` high and `bus_addr` equal to the request address. T1 is always followed by T2, and T2 by T3.
- R3: A read raises `bus_rd` and a write raises `bus_wr`. The strobe is high in T2, T3, every Tw and T4, and low in T1 and idle. A write also raises `bus_data_oe` over the same phases, with `bus_data_out` equal to the request data.
- R4: Ready is the AND of `chan_rdy` and NOT `aen`. It is sampled at each clock edge that ends a T3 or Tw cycle. If ready is low, the next cycle is Tw, and this repeats until ready is sampled high.
- R5: `min_wait` is sampled in T1. The cycle cannot reach T4 until at least that many Tw cycles have occurred. The number of Tw cycles equals the larger of `min_wait` and the number of not-ready samples taken during T3 and Tw.
- R6: For a read, `bus_data_in` is captured at the clock edge that ends the last T3 or Tw cycle. The captured value appears on `rd_data` with `rd_valid` high during T4 only. A write never raises `rd_valid`.
- R7: T4 is always followed by idle. `busy` is high from the cycle after a request is accepted until the block is back in idle.
- R8: While `aen` is high, `bus_ale`, `bus_rd`, `bus_wr`, `bus_addr_oe` and `bus_data_oe` are all low. A request that arrives in idle while `aen` is high is held: `t_state` stays 0 and `busy` is high. T1 begins on the first clock edge at which `aen` is sampled low.
- R9: A request presented while `busy` is high is ignored. The running cycle keeps its own address, and the block returns to idle with `busy` low afterwards.
- R10: If `aen` rises during T3, the next cycle is Tw with every strobe and enable low. Once `aen` falls, the cycle continues to T4 as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request, taken in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Transfer address |
| req_wdata | input | DATA_W (8) | Write data |
| min_wait | input | WAIT_W (3) | Minimum wait phases, sampled in T1 |
| chan_rdy | input | 1 | Slot channel-ready line, high = ready |
| aen | input | 1 | DMA owns the bus when high |
| bus_data_in | input | DATA_W (8) | Data returned by memory or I/O |
| busy | output | 1 | A request is pending or in progress |
| t_state | output | 3 | Current phase code |
| bus_ale | output | 1 | Address latch enable |
| bus_addr | output | ADDR_W (20) | Address value |
| bus_addr_oe | output | 1 | Address output enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_data_out | output | DATA_W (8) | Write data value |
| bus_data_oe | output | 1 | Write data output enable |
| rd_data | output | DATA_W (8) | Captured read data |
| rd_valid | output | 1 | `rd_data` valid, high in T4 of a read |

## Verification
A phase register in the wrong state shows on `t_state`, and on the strobes and enables, in the same cycle. A skipped or extra Tw cycle moves the rise of `rd_valid` and the fall of the strobe by exactly one clock per phase. A wait counter that is loaded wrongly or decrements wrongly therefore appears within at most eight cycles of T3, as a T4 that comes too early or too late. A wrong ownership gate appears at once as an enable that is high while `aen` is high, or as a T1 that starts under `aen`. A wrong data capture point appears in T4 as a mismatch between `rd_data` and the value presented on `bus_data_in` at the final sampling edge.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_TW   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;
endpackage

// File: rtl/bcs_ready_gen.sv
// Combines the slot ready line with bus ownership.
module bcs_ready_gen (
    input  logic chan_rdy,
    input  logic aen,
    output logic ready,
    output logic bus_free
);
    always_comb begin
        bus_free = ~aen;
        ready    = chan_rdy & ~aen;
    end
endmodule

// File: rtl/bcs_seq.sv
// Phase sequencer: request capture, wait counting, read data capture.
module bcs_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] min_wait,
    input  logic              ready,
    input  logic              bus_free,
    input  logic [DATA_W-1:0] bus_data_in,
    output tstate_e           st,
    output logic              cyc_write,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);
    typedef struct packed {
        tstate_e           st;
        logic              pend;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [WAIT_W-1:0] cnt;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        case (seq_q.st)
            TS_IDLE: begin
                if (!seq_q.pend && req_valid) begin
                    seq_d.wr    = req_write;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    if (bus_free) begin
                        seq_d.st = TS_T1;
                    end else begin
                        seq_d.pend = 1'b1;
                    end
                end else if (seq_q.pend && bus_free) begin
                    seq_d.pend = 1'b0;
                    seq_d.st   = TS_T1;
                end
            end
            TS_T1: begin
                seq_d.cnt = min_wait;
                seq_d.st  = TS_T2;
            end
            TS_T2: begin
                seq_d.st = TS_T3;
            end
            TS_T3, TS_TW: begin
                if (seq_q.cnt == '0 && ready) begin
                    seq_d.st = TS_T4;
                    if (!seq_q.wr) begin
                        seq_d.rdata  = bus_data_in;
                        seq_d.rvalid = 1'b1;
                    end
                end else begin
                    seq_d.st = TS_TW;
                    if (seq_q.cnt != '0) begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            TS_T4: begin
                seq_d.st = TS_IDLE;
            end
            default: begin
                seq_d.st = TS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        st        = seq_q.st;
        cyc_write = seq_q.wr;
        cyc_addr  = seq_q.addr;
        cyc_wdata = seq_q.wdata;
        rd_data   = seq_q.rdata;
        rd_valid  = seq_q.rvalid;
        busy      = (seq_q.st != TS_IDLE) || seq_q.pend;
    end
endmodule

// File: rtl/bcs_strobe_dec.sv
// Decodes the phase into strobes and output enables.
module bcs_strobe_dec
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  tstate_e           st,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic              bus_free,
    output logic              bus_ale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe
);
    logic in_cycle;
    logic strobe_ph;

    always_comb begin
        in_cycle     = (st != TS_IDLE);
        strobe_ph    = (st == TS_T2) || (st == TS_T3) || (st == TS_TW) || (st == TS_T4);
        bus_addr     = cyc_addr;
        bus_data_out = cyc_wdata;
        bus_ale      = (st == TS_T1) && bus_free;
        bus_addr_oe  = in_cycle && bus_free;
        bus_rd       = strobe_ph && !cyc_write && bus_free;
        bus_wr       = strobe_ph && cyc_write && bus_free;
        bus_data_oe  = strobe_ph && cyc_write && bus_free;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] min_wait,
    input  logic              chan_rdy,
    input  logic              aen,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              busy,
    output logic [2:0]        t_state,
    output logic              bus_ale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              ready;
    logic              bus_free;
    tstate_e           st;
    logic              cyc_write;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;

    bcs_ready_gen u_ready (
        .chan_rdy (chan_rdy),
        .aen      (aen),
        .ready    (ready),
        .bus_free (bus_free)
    );

    bcs_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .min_wait    (min_wait),
        .ready       (ready),
        .bus_free    (bus_free),
        .bus_data_in (bus_data_in),
        .st          (st),
        .cyc_write   (cyc_write),
        .cyc_addr    (cyc_addr),
        .cyc_wdata   (cyc_wdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .busy        (busy)
    );

    bcs_strobe_dec #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .st           (st),
        .cyc_write    (cyc_write),
        .cyc_addr     (cyc_addr),
        .cyc_wdata    (cyc_wdata),
        .bus_free     (bus_free),
        .bus_ale      (bus_ale),
        .bus_addr     (bus_addr),
        .bus_addr_oe  (bus_addr_oe),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe)
    );

    assign t_state = st;
endmodule

// File: rtl/bcs_checks.sv
module bcs_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] t_state,
    input logic       chan_rdy,
    input logic       aen,
    input logic       bus_ale,
    input logic       bus_addr_oe,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_data_oe,
    input logic       rd_valid
);
    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd1 |=> t_state == 3'd2); // R2
    AST_T2_TO_T3: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd2 |=> t_state == 3'd3); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd0 |-> !(bus_rd || bus_wr || bus_data_oe)); // R3
    AST_NOT_READY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (t_state == 3'd3 || t_state == 3'd4) && !chan_rdy |=> t_state == 3'd4); // R4
    AST_T4_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd5 |-> $past(chan_rdy && !aen)); // R4
    AST_RDVALID_IN_T4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> t_state == 3'd5); // R6
    AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd5 |=> t_state == 3'd0); // R7
    AST_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> !(bus_rd || bus_wr || bus_ale || bus_addr_oe || bus_data_oe)); // R8
    AST_NO_START_UNDER_AEN: assert property (@(posedge clk) disable iff (!rst_n)
        t_state == 3'd1 |-> !$past(aen)); // R8
endmodule

bind bus_cycle_seq bcs_checks u_bcs_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .t_state     (t_state),
    .chan_rdy    (chan_rdy),
    .aen         (aen),
    .bus_ale     (bus_ale),
    .bus_addr_oe (bus_addr_oe),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_data_oe (bus_data_oe),
    .rd_valid    (rd_valid)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {write, min_wait[2:0], not_ready_samples[3:0], addr[19:0], data[7:0]}
    localparam logic [35:0] VEC [0:NVEC-1] = '{
        {1'b0, 3'd0, 4'd0, 20'h12345, 8'hA5},
        {1'b1, 3'd0, 4'd0, 20'hF0F0F, 8'h3C},
        {1'b0, 3'd2, 4'd0, 20'h00001, 8'h5A},
        {1'b0, 3'd0, 4'd3, 20'h80000, 8'hC3},
        {1'b1, 3'd3, 4'd1, 20'h7FFFF, 8'h81},
        {1'b0, 3'd1, 4'd4, 20'hAAAAA, 8'h0F},
        {1'b1, 3'd7, 4'd0, 20'hFFFFF, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  min_wait = '0;
    logic        chan_rdy = 1'b1;
    logic        aen = 1'b0;
    logic [7:0]  bus_data_in = '0;
    logic        busy, bus_ale, bus_addr_oe, bus_rd, bus_wr, bus_data_oe, rd_valid;
    logic [2:0]  t_state;
    logic [19:0] bus_addr;
    logic [7:0]  bus_data_out, rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .min_wait (min_wait),
        .chan_rdy (chan_rdy), .aen (aen), .bus_data_in (bus_data_in),
        .busy (busy), .t_state (t_state), .bus_ale (bus_ale), .bus_addr (bus_addr),
        .bus_addr_oe (bus_addr_oe), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_data_out (bus_data_out), .bus_data_oe (bus_data_oe),
        .rd_data (rd_data), .rd_valid (rd_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [35:0] v);
        logic       wr   = v[35];
        int         mw   = int'(v[34:32]);
        int         low  = int'(v[31:28]);
        logic [19:0] ad  = v[27:8];
        logic [7:0] dt   = v[7:0];
        int         tw   = (mw > low) ? mw : low;
        int         lowcnt = 0;
        logic [2:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = dt;
        min_wait = 3'(mw); bus_data_in = wr ? ~dt : dt; chan_rdy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 5 + tw; c++) begin
            if (c == 0) exp = 3'd1;
            else if (c == 1) exp = 3'd2;
            else if (c == 2) exp = 3'd3;
            else if (c < 3 + tw) exp = 3'd4;
            else if (c == 3 + tw) exp = 3'd5;
            else exp = 3'd0;
            chk(exp == 3'd1 ? "R2 phase" : (exp == 3'd4 ? "R5 wait count" : "R4 phase"),
                32'(t_state), 32'(exp));
            if (exp == 3'd1) begin
                chk("R2 ale", 32'(bus_ale), 32'd1);
                chk("R2 addr", 32'(bus_addr), 32'(ad));
            end
            chk("R3 rd strobe", 32'(bus_rd), 32'(!wr && exp >= 3'd2));
            chk("R3 wr strobe", 32'(bus_wr), 32'(wr && exp >= 3'd2));
            chk("R3 data oe", 32'(bus_data_oe), 32'(wr && exp >= 3'd2));
            if (wr && exp == 3'd2) chk("R3 write data", 32'(bus_data_out), 32'(dt));
            chk("R6 rd_valid", 32'(rd_valid), 32'(!wr && exp == 3'd5));
            if (!wr && exp == 3'd5) chk("R6 rd_data", 32'(rd_data), 32'(dt));
            chk("R7 busy", 32'(busy), 32'(exp != 3'd0));
            if (exp == 3'd3 || exp == 3'd4) begin
                chan_rdy = (lowcnt < low) ? 1'b0 : 1'b1;
                lowcnt++;
            end else begin
                chan_rdy = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 state", 32'(t_state), 32'd0);
        chk("R1 strobes", 32'({bus_ale, bus_addr_oe, bus_rd, bus_wr, bus_data_oe}), 32'd0);
        chk("R1 busy/rd_valid", 32'({busy, rd_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R8 request held while DMA owns the bus
        aen = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h11111; min_wait = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 held idle", 32'(t_state), 32'd0);
        chk("R8 busy while pending", 32'(busy), 32'd1);
        chk("R8 no drive", 32'({bus_ale, bus_addr_oe, bus_rd, bus_wr, bus_data_oe}), 32'd0);
        @(negedge clk);
        chk("R8 still held", 32'(t_state), 32'd0);
        aen = 1'b0;
        @(negedge clk);
        chk("R8 starts T1", 32'(t_state), 32'd1);
        chk("R8 held addr", 32'(bus_addr), 32'h11111);
        for (int k = 0; k < 10 && t_state != 3'd0; k++) @(negedge clk);
        chk("R8 finished", 32'(t_state), 32'd0);

        // R9 request during a cycle is ignored
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0ABCD; req_wdata = 8'h66;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 in T2", 32'(t_state), 32'd2);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h54321;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 addr kept", 32'(bus_addr), 32'h0ABCD);
        chk("R9 still write", 32'(bus_wr), 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R9 back to idle", 32'(t_state), 32'd0);
        @(negedge clk);
        chk("R9 no second cycle", 32'(t_state), 32'd0);
        chk("R9 not busy", 32'(busy), 32'd0);

        // R10 aen rising during T3
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h22222; bus_data_in = 8'h9D;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 in T3", 32'(t_state), 32'd3);
        aen = 1'b1;
        @(negedge clk);
        chk("R10 wait under aen", 32'(t_state), 32'd4);
        chk("R10 released bus", 32'({bus_addr_oe, bus_rd}), 32'd0);
        aen = 1'b0;
        @(negedge clk);
        chk("R10 resumes T4", 32'(t_state), 32'd5);
        chk("R10 read strobe back", 32'(bus_rd), 32'd1);
        chk("R10 read data", 32'(rd_data), 32'h9D);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule